// File: doc/BRIEF.md
# Rotation-Angle Eigenvalue Sequence Generator

This block turns a fractional rotation angle α into a continuous stream of complex unit phasors e^{jkα}, one per sample clock. A frame strobe, pulsed once every N sample clocks, loads a new angle into a holding register. Each enabled clock, an index counter supplies the next k. The product k·α is registered and then fed to a pipelined rotation engine, which returns the cosine as the real part and the sine as the imaginary part.

The index sequence is not a plain count. It runs 0, 1, …, N-2 and then jumps to a final value M before it wraps to 0. M is N-1 for odd N and N for even N. A parameterised delay line on the outputs lines the block's latency up with a parallel datapath of the same transform length. A valid flag travels with every sample, so a downstream consumer can tell enabled phasors from idle cycles.

Top module: `phasor_seq_gen`

## Requirements
- R1: The angle used for the phase products is loaded from `angle_in` only on a clock where `frame_stb` is high; on all other clocks changes on `angle_in` have no effect on the outputs.
- R2: On each clock with `en` high the index advances 0, 1, …, N-2, then M, then back to 0, where M = N-1 for odd N and M = N for even N; with `en` low it holds.
- R3: The phase for an enabled clock is the index times the held angle, truncated to 16 bits, so it wraps modulo 2π through two's-complement overflow.
- R4: The angle word is 16-bit two's complement with the MSB weighing -π and bit i weighing π/2^(15-i), so the phase is value·π/32768. `re_out` is cos and `im_out` is sin of that phase, in signed format with 1.0 = 16384, each within 4 LSB.
- R5: The output for an index sampled with `en` high appears 1 + CI + D clocks after that edge, where CI is the rotation pipeline depth and D = N+1-CI when N > CI-1, else D = 0.
- R6: `vld_out` is high exactly for samples that come from a clock with `en` high; a clock with `en` low yields a sample with `vld_out` low and does not move the index.
- R7: A synchronous active-high reset clears the index to 0, the held angle to 0 and every valid flag in the pipeline.
- R8: Phases anywhere in [-π, π) converge, including -π (0x8000), ±π/2 (0x4000, 0xC000) and the values just below or beside them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | Once-per-frame strobe that loads `angle_in` |
| en | input | 1 | Advance the index and emit a valid sample |
| angle_in | input | 16 | Signed rotation angle, MSB weight -π |
| re_out | output | 16 | Real part (cosine), 1.0 = 16384 |
| im_out | output | 16 | Imaginary part (sine), 1.0 = 16384 |
| vld_out | output | 1 | Output sample derives from an enabled index |

## Verification
The bench builds two copies with a rotation pipeline depth of 16. One has N = 20: it is even, so the index jumps from 18 to 20, and it needs a five-stage alignment delay. The other has N = 7: it is odd, so the final index is 6, and it takes no alignment delay. These two values exercise both branches of the final-index rule and both branches of the delay rule. A set of directed angles at the quadrant edges and at -π is mixed with seeded random angles and enables. Large indices times large angles push the phase product through its wrap.

// File: rtl/phs_pkg.sv
package phs_pkg;

    localparam int ANG_W   = 16;              // angle word, MSB weight -pi
    localparam int OUT_W   = 16;              // output sample width
    localparam int ONE_SH  = 14;              // output 1.0 = 2**ONE_SH
    localparam int XY_G    = 2;               // extra fraction bits inside the rotator
    localparam int IW      = OUT_W + 2 + XY_G; // rotator x/y width
    localparam int Z_G     = 4;               // extra fraction bits on the residual angle
    localparam int ZW      = ANG_W + Z_G;     // residual angle width, pi = 2**(ZW-1)

    localparam real PI_R   = 3.14159265358979323846;

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] re;
        logic signed [OUT_W-1:0] im;
    } phasor_t;

    // Final index of the sequence: N-1 for odd N, N for even N.
    function automatic int last_index(input int n);
        return (n % 2 == 1) ? n - 1 : n;
    endfunction

    // Micro-rotation angle atan(2^-i) in residual-angle units.
    function automatic int atan_unit(input int i);
        real v;
        v = $atan(2.0 ** (-i)) / PI_R * (2.0 ** (ZW - 1));
        return int'(v);
    endfunction

    // Initial vector length that cancels the rotator gain after 'iters' steps.
    function automatic int gain_init(input int iters);
        real g;
        g = 1.0;
        for (int i = 0; i < iters; i++) begin
            g = g / $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        return int'(g * (2.0 ** (ONE_SH + XY_G)));
    endfunction

endpackage

// File: rtl/phs_index_ctr.sv
module phs_index_ctr
    import phs_pkg::*;
#(
    parameter int N     = 20,
    parameter int IDX_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] FINAL = IDX_W'(last_index(N));
    localparam logic [IDX_W-1:0] PEN   = IDX_W'(N - 2);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        if (idx_q == FINAL) begin
            idx_d = '0;
        end else if (idx_q == PEN) begin
            idx_d = FINAL;
        end else begin
            idx_d = idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (en) begin
            idx_q <= idx_d;
        end
    end

    assign idx = idx_q;

    // R2: after the final index comes 0
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (en && idx_q == FINAL) |=> (idx_q == '0));

    // R2: the penultimate index jumps to the final one
    p_jump_r2: assert property (@(posedge clk) disable iff (rst)
        (en && idx_q == PEN) |=> (idx_q == FINAL));

    // R2: index never sits at a skipped value
    p_range_r2: assert property (@(posedge clk) disable iff (rst)
        (idx_q < IDX_W'(N - 1)) || (idx_q == FINAL));

    // R6: a disabled clock leaves the index alone
    p_hold_idx_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(idx_q));

endmodule

// File: rtl/phs_angle_mul.sv
module phs_angle_mul
    import phs_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_stb,
    input  logic                    en,
    input  logic signed [ANG_W-1:0] angle_in,
    input  logic [IDX_W-1:0]        idx,
    output logic                    prod_vld,
    output logic signed [ANG_W-1:0] prod
);

    logic signed [ANG_W-1:0] ang_q;
    logic signed [ANG_W-1:0] prod_q;
    logic                    pvld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ang_q <= '0;
        end else if (frame_stb) begin
            ang_q <= angle_in;
        end
    end

    // Product truncated to the angle width: wraps modulo 2*pi.
    always_ff @(posedge clk) begin
        prod_q <= ANG_W'($signed({1'b0, idx}) * ang_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pvld_q <= 1'b0;
        end else begin
            pvld_q <= en;
        end
    end

    assign prod     = prod_q;
    assign prod_vld = pvld_q;

    // R1: held angle changes only on the frame strobe
    p_hold_ang_r1: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(ang_q));

    // R3: index zero always yields a zero phase
    p_zero_phase_r3: assert property (@(posedge clk) disable iff (rst)
        (en && idx == '0) |=> (prod_q == '0 && pvld_q));

endmodule

// File: rtl/phs_cordic.sv
module phs_cordic
    import phs_pkg::*;
#(
    parameter int STAGES = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic signed [ANG_W-1:0] in_ang,
    output phasor_t                 out
);

    localparam int ITERS = STAGES - 1;
    localparam logic signed [IW-1:0] X0      = IW'(gain_init(ITERS));
    localparam logic signed [ZW-1:0] QUARTER = ZW'(2 ** (ZW - 2));
    localparam int ONE      = 2 ** ONE_SH;
    localparam longint MAG_LO = longint'(ONE - 12) * longint'(ONE - 12);
    localparam longint MAG_HI = longint'(ONE + 12) * longint'(ONE + 12);

    logic                 vld_s [ITERS+1];
    logic signed [IW-1:0] x_s   [ITERS+1];
    logic signed [IW-1:0] y_s   [ITERS+1];
    logic signed [ZW-1:0] z_s   [ITERS];

    // Quadrant pre-rotation: bring the residual into [-pi/2, pi/2).
    logic signed [ZW-1:0] z_in;
    logic signed [IW-1:0] x_pre;
    logic signed [IW-1:0] y_pre;
    logic signed [ZW-1:0] z_pre;

    assign z_in = $signed({in_ang, {Z_G{1'b0}}});

    always_comb begin
        case (in_ang[ANG_W-1:ANG_W-2])
            2'b01: begin
                x_pre = '0;
                y_pre = X0;
                z_pre = z_in - QUARTER;
            end
            2'b10: begin
                x_pre = '0;
                y_pre = -X0;
                z_pre = z_in + QUARTER;
            end
            default: begin
                x_pre = X0;
                y_pre = '0;
                z_pre = z_in;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_s[0] <= 1'b0;
        end else begin
            vld_s[0] <= in_vld;
        end
    end

    always_ff @(posedge clk) begin
        x_s[0] <= x_pre;
        y_s[0] <= y_pre;
        z_s[0] <= z_pre;
    end

    for (genvar i = 0; i < ITERS; i++) begin : g_iter
        localparam logic signed [ZW-1:0] AT = ZW'(atan_unit(i));
        logic up;
        assign up = ~z_s[i][ZW-1];

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_s[i+1] <= 1'b0;
            end else begin
                vld_s[i+1] <= vld_s[i];
            end
        end

        always_ff @(posedge clk) begin
            if (up) begin
                x_s[i+1] <= x_s[i] - (y_s[i] >>> i);
                y_s[i+1] <= y_s[i] + (x_s[i] >>> i);
            end else begin
                x_s[i+1] <= x_s[i] + (y_s[i] >>> i);
                y_s[i+1] <= y_s[i] - (x_s[i] >>> i);
            end
        end

        if (i < ITERS - 1) begin : g_z
            always_ff @(posedge clk) begin
                z_s[i+1] <= up ? (z_s[i] - AT) : (z_s[i] + AT);
            end
        end
    end

    logic signed [OUT_W-1:0] re_w;
    logic signed [OUT_W-1:0] im_w;

    assign re_w = OUT_W'((x_s[ITERS] + $signed(IW'(2))) >>> XY_G);
    assign im_w = OUT_W'((y_s[ITERS] + $signed(IW'(2))) >>> XY_G);

    assign out.vld = vld_s[ITERS];
    assign out.re  = re_w;
    assign out.im  = im_w;

    // R4: every valid phasor has unit magnitude within a few LSB
    p_unit_mag_r4: assert property (@(posedge clk) disable iff (rst)
        vld_s[ITERS] |->
            ((longint'(re_w) * longint'(re_w) + longint'(im_w) * longint'(im_w)) >= MAG_LO &&
             (longint'(re_w) * longint'(re_w) + longint'(im_w) * longint'(im_w)) <= MAG_HI));

endmodule

// File: rtl/phs_align_delay.sv
module phs_align_delay
    import phs_pkg::*;
#(
    parameter int DLY = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  phasor_t din,
    output phasor_t dout
);

    if (DLY == 0) begin : g_pass
        assign dout = din;
    end else begin : g_line
        phasor_t line_q [DLY];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < DLY; j++) begin
                    line_q[j].vld <= 1'b0;
                end
            end else begin
                line_q[0].vld <= din.vld;
                for (int j = 1; j < DLY; j++) begin
                    line_q[j].vld <= line_q[j-1].vld;
                end
            end
        end

        always_ff @(posedge clk) begin
            line_q[0].re <= din.re;
            line_q[0].im <= din.im;
            for (int j = 1; j < DLY; j++) begin
                line_q[j].re <= line_q[j-1].re;
                line_q[j].im <= line_q[j-1].im;
            end
        end

        assign dout = line_q[DLY-1];
    end

endmodule

// File: rtl/phasor_seq_gen.sv
module phasor_seq_gen
    import phs_pkg::*;
#(
    parameter int N  = 20,
    parameter int CI = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_stb,
    input  logic                    en,
    input  logic signed [ANG_W-1:0] angle_in,
    output logic signed [OUT_W-1:0] re_out,
    output logic signed [OUT_W-1:0] im_out,
    output logic                    vld_out
);

    localparam int IDX_W = $clog2(N + 1);
    localparam int ALIGN = (N > CI - 1) ? (N + 1 - CI) : 0;

    logic [IDX_W-1:0]        idx;
    logic                    prod_vld;
    logic signed [ANG_W-1:0] prod;
    phasor_t                 rot_out;
    phasor_t                 aligned;

    phs_index_ctr #(.N(N), .IDX_W(IDX_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .idx (idx)
    );

    phs_angle_mul #(.IDX_W(IDX_W)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .en        (en),
        .angle_in  (angle_in),
        .idx       (idx),
        .prod_vld  (prod_vld),
        .prod      (prod)
    );

    phs_cordic #(.STAGES(CI)) u_rot (
        .clk    (clk),
        .rst    (rst),
        .in_vld (prod_vld),
        .in_ang (prod),
        .out    (rot_out)
    );

    phs_align_delay #(.DLY(ALIGN)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (rot_out),
        .dout (aligned)
    );

    assign re_out  = aligned.re;
    assign im_out  = aligned.im;
    assign vld_out = aligned.vld;

endmodule

// File: tb/phasor_seq_gen_tb.sv
`timescale 1ns/1ps
module phasor_seq_gen_tb;

    localparam int CI     = 16;
    localparam int NA     = 20;
    localparam int NB     = 7;
    localparam int REGS_A = 1 + CI + ((NA > CI - 1) ? NA + 1 - CI : 0);
    localparam int REGS_B = 1 + CI + ((NB > CI - 1) ? NB + 1 - CI : 0);
    localparam int LMAX   = (REGS_A > REGS_B) ? REGS_A : REGS_B;
    localparam int RUN    = 4000;
    localparam int TOL    = 4;
    localparam real PI    = 3.14159265358979323846;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst = 1'b1;
    logic               en_c  [2];
    logic               stb_c [2];
    logic signed [15:0] angle_in = '0;
    logic signed [15:0] re_o [2];
    logic signed [15:0] im_o [2];
    logic               vld_o [2];

    initial begin
        en_c[0] = 1'b0; en_c[1] = 1'b0;
        stb_c[0] = 1'b0; stb_c[1] = 1'b0;
    end

    phasor_seq_gen #(.N(NA), .CI(CI)) u_dut (
        .clk(clk), .rst(rst), .frame_stb(stb_c[0]), .en(en_c[0]),
        .angle_in(angle_in), .re_out(re_o[0]), .im_out(im_o[0]), .vld_out(vld_o[0])
    );

    phasor_seq_gen #(.N(NB), .CI(CI)) u_dut_odd (
        .clk(clk), .rst(rst), .frame_stb(stb_c[1]), .en(en_c[1]),
        .angle_in(angle_in), .re_out(re_o[1]), .im_out(im_o[1]), .vld_out(vld_o[1])
    );

    int n_checks = 0;
    int n_err    = 0;
    int wd_fail  = 0;
    int cyc      = 0;

    // model state
    int          m_idx   [2];
    logic [15:0] m_ang   [2];
    logic        m_fresh [2];
    logic        e_v   [2][LMAX];
    logic [15:0] e_ph  [2][LMAX];
    int          e_tag [2][LMAX];
    logic        rst_seen = 1'b0;

    logic [15:0] dir_ang [10] = '{16'h8000, 16'h7FFF, 16'h4000, 16'h3FFF, 16'hC000,
                                  16'hBFFF, 16'h0001, 16'hFFFF, 16'h0800, 16'h7000};
    int dir_ptr = 0;

    function automatic int cfg_n(input int c);
        return (c == 0) ? NA : NB;
    endfunction

    function automatic int cfg_regs(input int c);
        return (c == 0) ? REGS_A : REGS_B;
    endfunction

    function automatic int fin_idx(input int n);
        return (n % 2 == 1) ? n - 1 : n;
    endfunction

    function automatic int next_idx(input int k, input int n);
        if (k == fin_idx(n)) return 0;
        if (k == n - 2) return fin_idx(n);
        return k + 1;
    endfunction

    function automatic logic is_corner(input logic [15:0] a);
        for (int j = 0; j < 6; j++) begin
            if (a == dir_ang[j]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R4";
        endcase
    endfunction

    function automatic int exp_cos(input logic [15:0] ph);
        real rad;
        rad = $itor($signed(ph)) * PI / 32768.0;
        return int'(16384.0 * $cos(rad));
    endfunction

    function automatic int exp_sin(input logic [15:0] ph);
        real rad;
        rad = $itor($signed(ph)) * PI / 32768.0;
        return int'(16384.0 * $sin(rad));
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference model: advances on the same edge as the design.
    always @(posedge clk) begin
        rst_seen = rst;
        for (int c = 0; c < 2; c++) begin
            if (rst) begin
                m_idx[c]   = 0;
                m_ang[c]   = '0;
                m_fresh[c] = 1'b1;
                for (int j = 0; j < LMAX; j++) begin
                    e_v[c][j]   = 1'b0;
                    e_ph[c][j]  = '0;
                    e_tag[c][j] = 7;
                end
            end else begin
                int          full;
                logic [15:0] ph;
                int          tg;
                full = m_idx[c] * int'($signed(m_ang[c]));
                ph   = full[15:0];
                if (!en_c[c])                               tg = 6;
                else if (m_fresh[c])                        tg = 7;
                else if (m_idx[c] == fin_idx(cfg_n(c)))     tg = 2;
                else if (is_corner(m_ang[c]))               tg = 8;
                else if (full != int'($signed(ph)))         tg = 3;
                else if (angle_in != m_ang[c])              tg = 1;
                else                                        tg = 4;
                for (int j = LMAX - 1; j > 0; j--) begin
                    e_v[c][j]   = e_v[c][j-1];
                    e_ph[c][j]  = e_ph[c][j-1];
                    e_tag[c][j] = e_tag[c][j-1];
                end
                e_v[c][0]   = en_c[c];
                e_ph[c][0]  = ph;
                e_tag[c][0] = tg;
                if (en_c[c]) m_idx[c] = next_idx(m_idx[c], cfg_n(c));
                if (stb_c[c]) begin
                    m_ang[c]   = angle_in;
                    m_fresh[c] = 1'b0;
                end
            end
        end
    end

    // Checks, then stimulus for the next edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int c = 0; c < 2; c++) begin
            int  last;
            last = cfg_regs(c) - 1;
            n_checks = n_checks + 1;
            if (vld_o[c] !== e_v[c][last]) begin
                n_err = n_err + 1;
                $display("FAIL %s N=%0d cyc=%0d: vld=%0b expected %0b",
                         rst_seen ? "R7" : (e_tag[c][last] == 6 ? "R6" : "R5"),
                         cfg_n(c), cyc, vld_o[c], e_v[c][last]);
            end else if (e_v[c][last] && !rst_seen) begin
                int er;
                int ei;
                er = exp_cos(e_ph[c][last]);
                ei = exp_sin(e_ph[c][last]);
                n_checks = n_checks + 1;
                if (iabs(int'(re_o[c]) - er) > TOL || iabs(int'(im_o[c]) - ei) > TOL) begin
                    n_err = n_err + 1;
                    $display("FAIL %s N=%0d cyc=%0d ph=%h: re=%0d im=%0d expected re=%0d im=%0d",
                             tag_name(e_tag[c][last]), cfg_n(c), cyc, e_ph[c][last],
                             re_o[c], im_o[c], er, ei);
                end
            end
        end

        // stimulus
        rst = (cyc < 5) || (cyc >= 1500 && cyc < 1504);
        for (int c = 0; c < 2; c++) begin
            if (cyc >= 2000 && cyc < 2060) begin
                en_c[c] = 1'b0;
            end else if (cyc >= 5 && cyc < 8) begin
                en_c[c] = 1'b0;
            end else begin
                en_c[c] = ($urandom % 100) < 85;
            end
            stb_c[c] = !rst && en_c[c] && (m_idx[c] == 0) &&
                       (cyc > 5 + 3 * cfg_n(c)) && !(cyc >= 1504 && cyc < 1504 + 2 * cfg_n(c));
        end
        if ((stb_c[0] || stb_c[1]) && dir_ptr < 10) begin
            angle_in = dir_ang[dir_ptr];
            dir_ptr  = dir_ptr + 1;
        end else begin
            angle_in = 16'($urandom);
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err + wd_fail, n_checks + wd_fail);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (RUN) @(posedge clk);
        @(negedge clk);
        #1;
        summary();
    end

    initial begin
        #(4.0 * 100000);
        wd_fail = 1;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

endmodule